// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column addresses of one SDRAM read or write burst, one address per enabled clock. A start strobe loads an 8-bit starting column together with a burst-length code and an ordering selection. From the next cycle on, the block presents the columns of the burst in the chosen order until the burst completes, a stop request arrives, or a fresh start replaces it. A memory controller uses the output column and its valid flag to drive the column address of successive data beats. The done flag tells the controller that the current beat is the last one.

Finite bursts of 2, 4 or 8 beats stay inside their burst-aligned block of columns. The low address bits count up with wrap-around in linear mode. In interleaved mode they are the starting bits XOR the beat number. A full-page burst walks all 256 columns of a row in linear order. It wraps from the top column to zero and runs until it is stopped or restarted. A clock-enable input freezes the whole sequence while it is low.

Top module: `sdr_burst_colgen`

## Requirements
- R1: In a clock cycle where `rst_n` is sampled low, `col_valid` and `last_beat` are driven to 0 and `col_out` to 0, even in the middle of a burst.
- R2: A `start` sampled high at a rising edge with `clk_en` high makes `col_valid` high from the next cycle, with `start_col` as the first column. A start during an active burst restarts from the new column. When `start` and `stop` are sampled together, the start wins.
- R3: `bl_sel` selects the burst length as follows: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives a full page. The unused codes 4, 5 and 6 give a 1-beat burst.
- R4: With `order_sel` = 0 (linear) and a finite length BL, the column bits above the low log2(BL) bits equal those of `start_col`. The low bits of beat k equal (low bits of `start_col` + k) mod BL.
- R5: With `order_sel` = 1 (interleaved) and a finite length BL, the upper bits are fixed as in R4. The low log2(BL) bits of beat k equal the low bits of `start_col` XOR k. A full-page burst ignores `order_sel` and runs linearly.
- R6: A full-page burst steps the column by +1 on every enabled cycle and wraps from 255 to 0. It never asserts `last_beat` and continues until a stop or a new start.
- R7: `last_beat` is high exactly during the final beat of a finite burst. At the next enabled edge without a start, `col_valid` falls.
- R8: A `stop` sampled high at an enabled edge without `start` drives `col_valid` low from the next cycle, and no further column is produced.
- R9: While `clk_en` is sampled low, `col_out`, `col_valid` and `last_beat` keep their values, and `start` and `stop` are ignored.
- R10: Whenever `col_valid` is low, `col_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Advances the sequence when high; freezes it when low |
| start | input | 1 | Loads a new burst |
| start_col | input | 8 | Starting column of the burst |
| bl_sel | input | 3 | Burst-length code (see R3) |
| order_sel | input | 1 | 0 = linear, 1 = interleaved |
| stop | input | 1 | Ends the current burst |
| col_out | output | 8 | Column of the current beat |
| col_valid | output | 1 | A beat is being presented |
| last_beat | output | 1 | Current beat is the final one of a finite burst |

## Verification
The bench starts bursts at columns whose low bits are not zero, so that both wrap inside the aligned block and the XOR pattern are exercised. A design that carried into the upper bits, or that added where it should XOR, would then show a wrong column mid-burst. A full-page burst is run past column 255, which would expose a design that stopped at the top, raised the done flag, or jumped to the start column instead of zero. Stop, start-over-start, start together with stop, reset mid-burst and clock-enable low with strobes pending are all driven. These catch a sequence that overruns a stop, ignores a restart, or reacts to strobes while frozen.

// File: rtl/colgen_pkg.sv
// Package: shared constants and types for the burst column generator.
// Assumes column addresses are at most a few tens of bits wide.
package colgen_pkg;

    // Default column width: 256 columns per row
    localparam int COL_W_DEF       = 8;
    // Default width of the burst-length code
    localparam int LEN_W_DEF       = 3;
    // Largest finite burst, as log2 of the beat count (8 beats)
    localparam int MAX_LOG2_BL_DEF = 3;

    // Beat ordering selection
    typedef enum logic {
        ORDER_LINEAR     = 1'b0,
        ORDER_INTERLEAVE = 1'b1
    } order_e;

endpackage

// File: rtl/colgen_len_decode.sv
// Module: colgen_len_decode
// Turns a burst-length code into a low-bit mask (BL-1) and a full-page flag.
// Assumes: code c <= MAX_LOG2_BL means 2**c beats; the all-ones code means
// full page; any other code means a single beat.
module colgen_len_decode #(
    parameter int COL_W       = 8,
    parameter int LEN_W       = 3,
    parameter int MAX_LOG2_BL = 3
) (
    input  logic [LEN_W-1:0] len_code,
    output logic [COL_W-1:0] low_mask,
    output logic             full_page
);

    localparam logic [LEN_W-1:0] FULL_CODE = '1;
    localparam logic [LEN_W-1:0] MAX_CODE  = LEN_W'(MAX_LOG2_BL);

    logic legal_code;

    // Classify the code as full page, legal finite length, or reserved
    always_comb begin
        full_page  = (len_code == FULL_CODE);
        legal_code = (len_code <= MAX_CODE);
    end

    // One mask bit per column bit: set when that bit lies inside the burst block
    for (genvar gi = 0; gi < COL_W; gi++) begin : g_mask
        assign low_mask[gi] = full_page | (legal_code && (int'(len_code) > gi));
    end

endmodule

// File: rtl/colgen_beat_ctr.sv
// Module: colgen_beat_ctr
// Holds the burst-active flag and the beat index. Loads on a start, clears
// on a stop, and retires the burst after the last beat of a finite burst.
// Assumes: mask and full come from registered configuration; all state
// advances only on clock-enabled edges.
module colgen_beat_ctr #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_en,
    input  logic             load,
    input  logic             clear,
    input  logic [COL_W-1:0] mask,
    input  logic             full,
    output logic [COL_W-1:0] beat_idx,
    output logic             active,
    output logic             final_beat
);

    // Final beat: finite burst whose index has reached BL-1
    always_comb begin
        final_beat = active && !full && (beat_idx == mask);
    end

    // Active flag and beat index update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            beat_idx <= '0;
        end else if (adv_en) begin
            if (load) begin
                active   <= 1'b1;
                beat_idx <= '0;
            end else if (clear) begin
                active   <= 1'b0;
                beat_idx <= '0;
            end else if (active) begin
                if (final_beat) begin
                    active   <= 1'b0;
                    beat_idx <= '0;
                end else begin
                    beat_idx <= beat_idx + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/colgen_addr_map.sv
// Module: colgen_addr_map
// Maps the start column and beat index to the current column. Bits outside
// the mask come from the start column. Masked bits take the start+index
// sum (linear) or start XOR index (interleaved). The output is zero when idle.
// Assumes: beat_idx never exceeds mask for finite bursts.
module colgen_addr_map #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_col,
    input  logic [COL_W-1:0] beat_idx,
    input  logic [COL_W-1:0] mask,
    input  logic             interleave,
    input  logic             active,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] lin_sum;

    // Linear offset; carries past the mask are discarded per bit below
    always_comb begin
        lin_sum = base_col + beat_idx;
    end

    // Per-bit selection between fixed, linear and interleaved values
    for (genvar gb = 0; gb < COL_W; gb++) begin : g_bit
        logic low_bit;
        assign low_bit = interleave ? (base_col[gb] ^ beat_idx[gb]) : lin_sum[gb];
        assign col[gb] = active & (mask[gb] ? low_bit : base_col[gb]);
    end

endmodule

// File: rtl/sdr_burst_colgen.sv
// Module: sdr_burst_colgen (top)
// Burst column address generator. Latches the start column and burst
// configuration on an enabled start, then presents one column per enabled
// cycle via the beat counter and address map.
// Assumes: clk_en gates every state change; a start outranks a stop.
module sdr_burst_colgen #(
    parameter int COL_W       = colgen_pkg::COL_W_DEF,
    parameter int LEN_W       = colgen_pkg::LEN_W_DEF,
    parameter int MAX_LOG2_BL = colgen_pkg::MAX_LOG2_BL_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [LEN_W-1:0] bl_sel,
    input  logic             order_sel,
    input  logic             stop,
    output logic [COL_W-1:0] col_out,
    output logic             col_valid,
    output logic             last_beat
);

    import colgen_pkg::*;

    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    logic             dec_inter;

    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] mask_q;
    logic             full_q;
    logic             inter_q;

    logic [COL_W-1:0] beat_idx;
    logic             active;
    logic             final_beat;

    colgen_len_decode #(
        .COL_W       (COL_W),
        .LEN_W       (LEN_W),
        .MAX_LOG2_BL (MAX_LOG2_BL)
    ) u_len_dec (
        .len_code  (bl_sel),
        .low_mask  (dec_mask),
        .full_page (dec_full)
    );

    // Interleaving applies only to finite bursts
    always_comb begin
        dec_inter = (order_e'(order_sel) == ORDER_INTERLEAVE) && !dec_full;
    end

    // Burst configuration capture on an enabled start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            mask_q  <= '0;
            full_q  <= 1'b0;
            inter_q <= 1'b0;
        end else if (clk_en && start) begin
            base_q  <= start_col;
            mask_q  <= dec_mask;
            full_q  <= dec_full;
            inter_q <= dec_inter;
        end
    end

    colgen_beat_ctr #(
        .COL_W (COL_W)
    ) u_beat_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_en     (clk_en),
        .load       (start),
        .clear      (stop),
        .mask       (mask_q),
        .full       (full_q),
        .beat_idx   (beat_idx),
        .active     (active),
        .final_beat (final_beat)
    );

    colgen_addr_map #(
        .COL_W (COL_W)
    ) u_addr_map (
        .base_col   (base_q),
        .beat_idx   (beat_idx),
        .mask       (mask_q),
        .interleave (inter_q),
        .active     (active),
        .col        (col_out)
    );

    // Output flags
    always_comb begin
        col_valid = active;
        last_beat = final_beat;
    end

endmodule

// File: rtl/colgen_checker.sv
// Module: colgen_checker
// Port-level temporal checks for sdr_burst_colgen, bound to the top.
// Tracks from the ports alone whether the running burst is full page.
module colgen_checker #(
    parameter int COL_W = 8,
    parameter int LEN_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clk_en,
    input logic             start,
    input logic             stop,
    input logic [COL_W-1:0] start_col,
    input logic [LEN_W-1:0] bl_sel,
    input logic [COL_W-1:0] col_out,
    input logic             col_valid,
    input logic             last_beat
);

    logic fp_q;

    // Remember whether the latest accepted start requested a full page
    always_ff @(posedge clk) begin
        if (!rst_n) fp_q <= 1'b0;
        else if (clk_en && start) fp_q <= (bl_sel == '1);
    end

    assert_start_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && start |=> col_valid && (col_out == $past(start_col)));

    assert_done_retires_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && last_beat && !start |=> !col_valid);

    assert_burst_continues_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && col_valid && !last_beat && !stop |=> col_valid);

    assert_stop_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && stop && !start |=> !col_valid);

    assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(col_out) && $stable(col_valid) && $stable(last_beat));

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !col_valid |-> (col_out == '0) && !last_beat);

    assert_fullpage_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && col_valid && fp_q && !start && !stop
        |=> col_valid && !last_beat && (col_out == COL_W'($past(col_out) + 1'b1)));

endmodule

bind sdr_burst_colgen colgen_checker #(
    .COL_W (COL_W),
    .LEN_W (LEN_W)
) u_colgen_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en    (clk_en),
    .start     (start),
    .stop      (stop),
    .start_col (start_col),
    .bl_sel    (bl_sel),
    .col_out   (col_out),
    .col_valid (col_valid),
    .last_beat (last_beat)
);

// File: tb/sdr_burst_colgen_tb_top.sv
// Bench: behavioural per-cycle reference model compared on every clock.
module sdr_burst_colgen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 1'b0;
    logic       start = 1'b0;
    logic [7:0] start_col = '0;
    logic [2:0] bl_sel = '0;
    logic       order_sel = 1'b0;
    logic       stop = 1'b0;
    logic [7:0] col_out;
    logic       col_valid;
    logic       last_beat;

    always #5 clk = ~clk;

    sdr_burst_colgen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .start     (start),
        .start_col (start_col),
        .bl_sel    (bl_sel),
        .order_sel (order_sel),
        .stop      (stop),
        .col_out   (col_out),
        .col_valid (col_valid),
        .last_beat (last_beat)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    finished = 0;
    string phase = "R1";

    // Reference model state: m_len 0 means full page
    int m_act = 0, m_base = 0, m_len = 1, m_inter = 0, m_beat = 0;

    function automatic int len_of(input logic [2:0] code);
        case (code)
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            3'd7: return 0;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_col();
        int blk, off;
        if (m_len == 0) return (m_base + m_beat) % 256;
        blk = (m_base / m_len) * m_len;
        off = m_base % m_len;
        if (m_inter != 0) return blk + (off ^ m_beat);
        return blk + ((off + m_beat) % m_len);
    endfunction

    // Model update at each rising edge from the sampled inputs
    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0; m_beat = 0;
        end else if (clk_en) begin
            if (start) begin
                m_act = 1; m_base = int'(start_col); m_len = len_of(bl_sel);
                m_inter = (order_sel && m_len != 0) ? 1 : 0; m_beat = 0;
            end else if (stop) begin
                m_act = 0;
            end else if (m_act != 0) begin
                if (m_len != 0 && m_beat == m_len - 1) m_act = 0;
                else m_beat = (m_beat + 1) % 256;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp, input string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Compare outputs mid-cycle; watchdog
    always @(negedge clk) begin
        if (!finished) begin
            int e_done, e_col;
            cycles++;
            e_done = (m_act != 0 && m_len != 0 && m_beat == m_len - 1) ? 1 : 0;
            e_col  = (m_act != 0) ? exp_col() : 0;
            chk(phase, int'(col_valid), m_act, "col_valid");
            chk(phase, int'(last_beat), e_done, "last_beat");
            chk((m_act != 0) ? phase : "R10", int'(col_out), e_col, "col_out");
            if (cycles > 150000) begin
                n_bad++;
                $display("FAIL watchdog actual=hung expected=finished");
                finish_run();
            end
        end
    end

    task automatic drv(input logic st, input logic sp, input logic ce,
                       input logic [7:0] col, input logic [2:0] bl, input logic ord);
        @(posedge clk);
        #2;
        start = st; stop = sp; clk_en = ce; start_col = col; bl_sel = bl; order_sel = ord;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drv(1'b0, 1'b0, 1'b1, 8'h00, 3'd0, 1'b0);
    endtask

    initial begin
        // R1: reset state
        phase = "R1";
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        idle(2);
        // R4: linear finite bursts with unaligned starts
        phase = "R4";
        drv(1, 0, 1, 8'h2D, 3'd3, 0); idle(10);
        drv(1, 0, 1, 8'h13, 3'd2, 0); idle(6);
        drv(1, 0, 1, 8'h81, 3'd1, 0); idle(4);
        // R3: single beat and reserved codes
        phase = "R3";
        drv(1, 0, 1, 8'h55, 3'd0, 0); idle(3);
        drv(1, 0, 1, 8'h66, 3'd5, 1); idle(3);
        drv(1, 0, 1, 8'h77, 3'd6, 0); idle(3);
        drv(1, 0, 1, 8'h78, 3'd4, 0); idle(3);
        // R5: interleaved, and full page ignoring the order selection
        phase = "R5";
        drv(1, 0, 1, 8'h2D, 3'd3, 1); idle(10);
        drv(1, 0, 1, 8'h13, 3'd2, 1); idle(6);
        drv(1, 0, 1, 8'hFD, 3'd7, 1); idle(6);
        drv(0, 1, 1, 8'h00, 3'd0, 0); idle(2);
        // R6: full page wraps past 255 with no done
        phase = "R6";
        drv(1, 0, 1, 8'hFC, 3'd7, 0); idle(300);
        // R8: stop ends full page and finite bursts
        phase = "R8";
        drv(0, 1, 1, 8'h00, 3'd0, 0); idle(3);
        drv(1, 0, 1, 8'h40, 3'd3, 0); idle(3);
        drv(0, 1, 1, 8'h00, 3'd0, 0); idle(4);
        // R7: done on last beat, then idle
        phase = "R7";
        drv(1, 0, 1, 8'h0E, 3'd2, 1); idle(6);
        // R2: restart mid-burst; start together with stop
        phase = "R2";
        drv(1, 0, 1, 8'h10, 3'd3, 0); idle(2);
        drv(1, 0, 1, 8'hA7, 3'd3, 1); idle(10);
        drv(1, 1, 1, 8'h31, 3'd2, 0); idle(6);
        // R9: freeze with strobes pending
        phase = "R9";
        drv(1, 0, 1, 8'h58, 3'd3, 0); idle(2);
        drv(0, 0, 0, 8'h00, 3'd0, 0);
        drv(1, 0, 0, 8'hEE, 3'd1, 1);
        drv(0, 1, 0, 8'h00, 3'd0, 0);
        idle(10);
        drv(1, 0, 1, 8'hFE, 3'd7, 0); idle(1);
        drv(0, 0, 0, 8'h00, 3'd0, 0);
        drv(0, 1, 0, 8'h00, 3'd0, 0);
        idle(3);
        drv(0, 1, 1, 8'h00, 3'd0, 0); idle(2);
        // R1: reset in the middle of a burst
        phase = "R1";
        drv(1, 0, 1, 8'h20, 3'd3, 0); idle(1);
        @(posedge clk); #2 rst_n = 1'b0;
        @(posedge clk); #2 rst_n = 1'b1;
        idle(3);
        finish_run();
    end

endmodule